// File: doc/BRIEF.md
# Compact Register-Mapped UART

This block is a small asynchronous serial port. Software reaches it through a word-spaced register bus and pushes bytes into an 8-entry transmit queue or pops them from an 8-entry receive queue. The serial frames carry one start bit, 7 or 8 data bits sent least significant bit first, and one stop bit. There is no parity. The bit period comes from the system clock through a 16-bit divisor, with 8 sub-bit ticks to each bit.

One interrupt line reports either received data waiting or free room in the transmit queue, and only one of the two sources is reported at a time. Software drives a request-to-send output directly and can read back a synchronised clear-to-send input. It can also hold the line low to send a break. Software clears the separate receiver and transmitter enables while it changes the line settings.

Registers sit at byte address `index << 2`. Indices: 0 data, 1 interrupt enable, 2 interrupt identify, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 extra control, 9 extended status, 10 divisor. Reads return data in the same cycle. A read or write takes effect at the clock edge where `reg_sel` is high.

Top module: `compact_uart`

## Requirements
- R1: After reset: line status reads 0x60, interrupt identify reads 0x01, extra control reads 0x03, line control reads 0, `irq_o`=0, `txd_o`=1 and `rts_o`=0.
- R2: Each queue holds 8 bytes. A write to the data register while 8 bytes are queued is dropped. Line status bit 5 is 1 only while the transmit queue has room. Extended status bits 3:0 give the receive queue level and bits 7:4 give the transmit queue level.
- R3: Each transmitted frame is a 0 start bit, then the data bits least significant bit first, then a 1 stop bit. Every bit lasts 8*(divisor+1) clocks. While no frame is being sent and no break is set, `txd_o` stays 1.
- R4: Line control bits 1:0 = 11 selects 8 data bits, and any other value selects 7. In 7-bit mode a frame carries data bits 6:0, and a received byte reads back with bit 7 = 0.
- R5: A frame on `rxd_i` is sampled in the middle of each bit and queued. Line status bit 0 is 1 while the receive queue holds data, and reading the data register pops the oldest byte.
- R6: A frame that completes while the receive queue is full is dropped, and line status bit 1 is set. The flag stays set until line status is read, and the 8 bytes already queued are kept.
- R7: `irq_o` is 1 only when interrupt enable bits 3:2 are both 1 and an enabled source is active. Bit 0 enables receive data and bit 1 enables transmit room. Interrupt identify reads bit 0 = 1 when nothing is pending, bit 2 = receive, bit 1 = transmit. Receive wins when both sources are active.
- R8: Writing interrupt identify with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue.
- R9: Line control bit 6 forces `txd_o` to 0.
- R10: With extra control bit 1 = 0 no new frame starts and queued bytes wait, so line status bit 6 stays 0. With extra control bit 0 = 0 the line is ignored and nothing is queued.
- R11: Modem control bit 1 drives `rts_o`. Modem status bit 5 shows `cts_i` after a two-flop synchroniser.
- R12: Scratch is a plain 8-bit register and the divisor register reads back all 16 bits. Bits that are not implemented and indices 11 to 15 read 0. Writes to the read-only registers have no effect.
- R13: A low pulse on `rxd_i` that ends before the half-bit point is rejected as a false start, and no byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address (index in bits 5:2) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send, software driven |
| cts_i | input | 1 | Clear-to-send input |

## Verification
A table of frames runs through the transmitter and back into the receiver over a loopback. The table mixes divisors, both character lengths and data with alternating, all-ones and sparse bit patterns. This separates bit-order mistakes, wrong bit periods and mistakes in the 7-bit masking. Back-to-back transmit frames show that the queue keeps its order and drops the ninth byte. Frames driven by the bench into the receiver cover the overrun flag, the enables and the queue flushes. A short low pulse tells a real start bit from a glitch.

// File: rtl/compact_uart_pkg.sv
package compact_uart_pkg;

  localparam logic [3:0] RI_DATA  = 4'd0;
  localparam logic [3:0] RI_IEN   = 4'd1;
  localparam logic [3:0] RI_IID   = 4'd2;
  localparam logic [3:0] RI_LINE  = 4'd3;
  localparam logic [3:0] RI_MODEM = 4'd4;
  localparam logic [3:0] RI_LSTAT = 4'd5;
  localparam logic [3:0] RI_MSTAT = 4'd6;
  localparam logic [3:0] RI_SCR   = 4'd7;
  localparam logic [3:0] RI_XCTL  = 4'd8;
  localparam logic [3:0] RI_XSTAT = 4'd9;
  localparam logic [3:0] RI_DIV   = 4'd10;

  // character length select: only 2'b11 gives 8-bit characters
  function automatic logic wide_chars(input logic [1:0] sel);
    return sel == 2'b11;
  endfunction

  // index of the stop bit in the transmit bit sequence (0 = start)
  function automatic logic [3:0] stop_slot(input logic wide);
    return wide ? 4'd9 : 4'd8;
  endfunction

  // index of the last data bit for the receiver
  function automatic logic [2:0] last_data(input logic wide);
    return wide ? 3'd7 : 3'd6;
  endfunction

  // align a received shift register to a right-justified byte
  function automatic logic [7:0] align_rx(input logic wide, input logic [7:0] sh);
    return wide ? sh : {1'b0, sh[7:1]};
  endfunction

endpackage

// File: rtl/compact_uart_fifo.sv
module compact_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_q];
  assign level   = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= din;
  end

endmodule

// File: rtl/compact_uart_tick.sv
module compact_uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= div;
    else if (cnt_q == '0)    cnt_q <= div;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  // one pulse every div+1 clocks, first one div+1 clocks after restart
  assign tick = (cnt_q == '0) & ~restart;

endmodule

// File: rtl/compact_uart_tx.sv
module compact_uart_tx
  import compact_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             wide,
  input  logic             have_data,
  input  logic [7:0]       data,
  output logic             take,
  output logic             busy,
  output logic             line
);

  logic       active_q, line_q, wide_q;
  logic [3:0] slot_q;
  logic [2:0] sub_q;
  logic [7:0] sh_q;
  logic       tick;

  assign take = ~active_q & enable & have_data;
  assign busy = active_q;
  assign line = line_q;

  compact_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(take), .div(div), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      line_q   <= 1'b1;
      wide_q   <= 1'b0;
      slot_q   <= '0;
      sub_q    <= '0;
      sh_q     <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      line_q   <= 1'b0;
      wide_q   <= wide;
      slot_q   <= '0;
      sub_q    <= '0;
      sh_q     <= data;
    end else if (active_q && tick) begin
      if (sub_q == 3'd7) begin
        sub_q <= '0;
        if (slot_q == stop_slot(wide_q)) begin
          active_q <= 1'b0;
          line_q   <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
          if (slot_q + 4'd1 == stop_slot(wide_q)) begin
            line_q <= 1'b1;
          end else begin
            line_q <= sh_q[0];
            sh_q   <= {1'b0, sh_q[7:1]};
          end
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/compact_uart_rx.sv
module compact_uart_rx
  import compact_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             wide,
  input  logic             line,
  output logic             done,
  output logic [7:0]       char_out,
  output logic             char_wide
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e  st_q;
  logic [2:0] sub_q, cnt_q;
  logic [7:0] sh_q;
  logic       wide_q, done_q, tick, begin_frame;

  assign begin_frame = (st_q == S_IDLE) & enable & ~line;
  assign done        = done_q;
  assign char_out    = align_rx(wide_q, sh_q);
  assign char_wide   = wide_q;

  compact_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(begin_frame), .div(div), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sub_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (begin_frame) begin
          st_q   <= S_START;
          sub_q  <= '0;
          cnt_q  <= '0;
          wide_q <= wide;
        end
        S_START: if (tick) begin
          if (sub_q == 3'd3) begin
            sub_q <= '0;
            st_q  <= line ? S_IDLE : S_DATA;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (sub_q == 3'd7) begin
            sub_q <= '0;
            sh_q  <= {line, sh_q[7:1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == last_data(wide_q)) st_q <= S_STOP;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          if (sub_q == 3'd7) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/compact_uart.sv
module compact_uart
  import compact_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rts_o,
  input  logic              cts_i
);

  logic [IDX_W-1:0] idx;
  logic             wr_ev, rd_ev;
  logic [3:0]       ien_q;
  logic [1:0]       csel_q;
  logic             brk_q, rts_q, rx_en_q, tx_en_q, ovr_q;
  logic [7:0]       scr_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       rxd_sync_q, cts_sync_q;

  logic             tx_push, tx_take, tx_full, tx_empty, tx_busy, tx_line, tx_flush;
  logic [7:0]       tx_head;
  logic [LVL_W-1:0] tx_lvl;
  logic             rx_pop, rx_done, rx_full, rx_empty, rx_flush, rx_drop, rx_wide;
  logic [7:0]       rx_char, rx_head;
  logic [LVL_W-1:0] rx_lvl;
  logic             rx_src, tx_src, gate, iid_rx, iid_tx;
  logic             unused_bits;

  assign idx   = reg_addr[ADDR_W-1:2];
  assign wr_ev = reg_sel & reg_wr;
  assign rd_ev = reg_sel & ~reg_wr;
  assign unused_bits = &{1'b0, reg_addr[1:0]};

  function automatic logic hit(input logic [IDX_W-1:0] a, input logic [3:0] r);
    return a == IDX_W'(r);
  endfunction

  assign tx_push  = wr_ev & hit(idx, RI_DATA);
  assign rx_pop   = rd_ev & hit(idx, RI_DATA);
  assign rx_flush = wr_ev & hit(idx, RI_IID) & reg_wdata[1];
  assign tx_flush = wr_ev & hit(idx, RI_IID) & reg_wdata[2];
  assign rx_drop  = rx_done & rx_full;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      csel_q  <= '0;
      brk_q   <= 1'b0;
      rts_q   <= 1'b0;
      scr_q   <= '0;
      rx_en_q <= 1'b1;
      tx_en_q <= 1'b1;
      div_q   <= '0;
    end else if (wr_ev) begin
      if (hit(idx, RI_IEN))   ien_q  <= reg_wdata[3:0];
      if (hit(idx, RI_LINE)) begin
        csel_q <= reg_wdata[1:0];
        brk_q  <= reg_wdata[6];
      end
      if (hit(idx, RI_MODEM)) rts_q  <= reg_wdata[1];
      if (hit(idx, RI_SCR))   scr_q  <= reg_wdata[7:0];
      if (hit(idx, RI_XCTL)) begin
        rx_en_q <= reg_wdata[0];
        tx_en_q <= reg_wdata[1];
      end
      if (hit(idx, RI_DIV))   div_q  <= reg_wdata[DIV_W-1:0];
    end
  end

  // sticky overrun: a new drop wins over the clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovr_q <= 1'b0;
    else if (rx_drop)                   ovr_q <= 1'b1;
    else if (rd_ev && hit(idx, RI_LSTAT)) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_sync_q <= 2'b11;
      cts_sync_q <= 2'b00;
    end else begin
      rxd_sync_q <= {rxd_sync_q[0], rxd_i};
      cts_sync_q <= {cts_sync_q[0], cts_i};
    end
  end

  compact_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(reg_wdata[7:0]), .pop(tx_take), .dout(tx_head), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty)
  );

  compact_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_done),
    .din(rx_char), .pop(rx_pop), .dout(rx_head), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty)
  );

  compact_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(tx_en_q), .div(div_q),
    .wide(wide_chars(csel_q)), .have_data(~tx_empty), .data(tx_head),
    .take(tx_take), .busy(tx_busy), .line(tx_line)
  );

  compact_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_en_q), .div(div_q),
    .wide(wide_chars(csel_q)), .line(rxd_sync_q[1]),
    .done(rx_done), .char_out(rx_char), .char_wide(rx_wide)
  );

  // interrupt selection: receive has priority
  assign rx_src = ien_q[0] & ~rx_empty;
  assign tx_src = ien_q[1] & ~tx_full;
  assign gate   = &ien_q[3:2];
  assign iid_rx = gate & rx_src;
  assign iid_tx = gate & tx_src & ~rx_src;
  assign irq_o  = iid_rx | iid_tx;

  assign txd_o = brk_q ? 1'b0 : tx_line;
  assign rts_o = rts_q;

  always_comb begin
    reg_rdata = '0;
    unique case (idx)
      IDX_W'(RI_DATA):  reg_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      IDX_W'(RI_IEN):   reg_rdata[3:0] = ien_q;
      IDX_W'(RI_IID):   reg_rdata[2:0] = {iid_rx, iid_tx, ~irq_o};
      IDX_W'(RI_LINE):  reg_rdata[6:0] = {brk_q, 4'b0, csel_q};
      IDX_W'(RI_MODEM): reg_rdata[1]   = rts_q;
      IDX_W'(RI_LSTAT): reg_rdata[6:0] = {tx_empty & ~tx_busy, ~tx_full, 3'b0,
                                          ovr_q, ~rx_empty};
      IDX_W'(RI_MSTAT): reg_rdata[5]   = cts_sync_q[1];
      IDX_W'(RI_SCR):   reg_rdata[7:0] = scr_q;
      IDX_W'(RI_XCTL):  reg_rdata[1:0] = {tx_en_q, rx_en_q};
      IDX_W'(RI_XSTAT): begin
        reg_rdata[LVL_W-1:0]       = rx_lvl;
        reg_rdata[2*LVL_W-1:LVL_W] = tx_lvl;
      end
      IDX_W'(RI_DIV):   reg_rdata[DIV_W-1:0] = div_q;
      default:          reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/compact_uart_chk.sv
module compact_uart_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl,
  input logic             iid_rx,
  input logic             iid_tx,
  input logic             irq,
  input logic             rx_drop,
  input logic             ovr,
  input logic             tx_busy,
  input logic             brk,
  input logic             txd,
  input logic             tx_en,
  input logic             rx_done,
  input logic             rx_wide,
  input logic [7:0]       rx_char
);

  a_r2_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LVL_W'(DEPTH));

  a_r2_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= LVL_W'(DEPTH));

  a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iid_rx, iid_tx}));

  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_lvl != '0 || tx_lvl != LVL_W'(DEPTH)));

  a_r6_overrun_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovr);

  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !brk) |-> txd);

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_busy) |=> !tx_busy);

  a_r4_seven_bit_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_wide) |-> !rx_char[7]);

endmodule

bind compact_uart compact_uart_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .iid_rx(iid_rx), .iid_tx(iid_tx), .irq(irq_o), .rx_drop(rx_drop),
  .ovr(ovr_q), .tx_busy(tx_busy), .brk(brk_q), .txd(txd_o),
  .tx_en(tx_en_q), .rx_done(rx_done), .rx_wide(rx_wide), .rx_char(rx_char)
);

// File: tb/compact_uart_tb_top.sv
`timescale 1ns/1ps
module compact_uart_tb_top;

  typedef struct packed {
    logic [15:0] div;
    logic        wide;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd1, 1'b1, 8'hA5},
    '{16'd0, 1'b1, 8'h3C},
    '{16'd3, 1'b1, 8'h01},
    '{16'd1, 1'b0, 8'hFF},
    '{16'd2, 1'b0, 8'h55},
    '{16'd4, 1'b1, 8'h80},
    '{16'd1, 1'b0, 8'hC6}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        irq_o, txd_o, rts_o, cts_i = 1'b0;
  logic        loop_en = 1'b0, drv_rxd = 1'b1;
  logic        rxd_i;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  assign rxd_i = loop_en ? txd_o : drv_rxd;

  always #2.5 clk = ~clk;

  compact_uart dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .txd_o(txd_o), .rxd_i(rxd_i), .rts_o(rts_o), .cts_i(cts_i)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [15:0] v);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = v;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] idx, output logic [15:0] v);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = {idx, 2'b00};
    #1 v = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] idx, input logic [15:0] exp);
    logic [15:0] v;
    rd_reg(idx, v);
    check(req, v, exp);
  endtask

  // decode one frame from txd_o; returns at the middle of the stop bit
  task automatic get_tx(input int bc, input bit wide, output logic [7:0] val, output bit ok);
    int guard = 0;
    val = '0;
    while (txd_o !== 1'b0 && guard < 40 * bc + 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (bc / 2) @(negedge clk);
    ok = (txd_o === 1'b0);
    for (int i = 0; i < (wide ? 8 : 7); i++) begin
      repeat (bc) @(negedge clk);
      val[i] = txd_o;
    end
    repeat (bc) @(negedge clk);
    ok = ok && (txd_o === 1'b1);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit wide, input int bc);
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < (wide ? 8 : 7); i++) begin
      drv_rxd = b[i];
      repeat (bc) @(negedge clk);
    end
    drv_rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  function automatic int bit_clks(input logic [15:0] d);
    return 8 * (int'(d) + 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  got;
    bit          ok;
    int          lows;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 txd", {15'd0, txd_o}, 16'd1);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
    check("R1 rts", {15'd0, rts_o}, 16'd0);
    rd_check("R1 lstat", 4'd5, 16'h0060);
    rd_check("R1 iid", 4'd2, 16'h0001);
    rd_check("R1 xctl", 4'd8, 16'h0003);
    rd_check("R1 line", 4'd3, 16'h0000);

    // R12 register access and unused bits
    wr_reg(4'd7, 16'h1234);
    rd_check("R12 scratch", 4'd7, 16'h0034);
    wr_reg(4'd10, 16'hBEEF);
    rd_check("R12 divisor", 4'd10, 16'hBEEF);
    wr_reg(4'd1, 16'hFFFF);
    rd_check("R12 ien bits", 4'd1, 16'h000F);
    wr_reg(4'd1, 16'h0000);
    wr_reg(4'd5, 16'hFFFF);
    rd_check("R12 lstat write ignored", 4'd5, 16'h0060);
    rd_check("R12 index 12", 4'd12, 16'h0000);

    // R11 modem lines
    wr_reg(4'd4, 16'hFFFF);
    rd_check("R11 modem readback", 4'd4, 16'h0002);
    check("R11 rts high", {15'd0, rts_o}, 16'd1);
    wr_reg(4'd4, 16'h0000);
    check("R11 rts low", {15'd0, rts_o}, 16'd0);
    cts_i = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R11 cts set", 4'd6, 16'h0020);
    cts_i = 1'b0;
    repeat (3) @(negedge clk);
    rd_check("R11 cts clear", 4'd6, 16'h0000);

    // R7 interrupt gating and identify
    wr_reg(4'd1, 16'h0003);
    check("R7 no gate irq", {15'd0, irq_o}, 16'd0);
    rd_check("R7 no gate iid", 4'd2, 16'h0001);
    wr_reg(4'd1, 16'h000F);
    check("R7 tx room irq", {15'd0, irq_o}, 16'd1);
    rd_check("R7 tx iid", 4'd2, 16'h0002);
    wr_reg(4'd1, 16'h000D);
    check("R7 rx only idle irq", {15'd0, irq_o}, 16'd0);
    wr_reg(4'd1, 16'h0000);

    // R3 R4 R5 table of loopback frames
    loop_en = 1'b1;
    for (int k = 0; k < NV; k++) begin
      vec_t vc = VECS[k];
      logic [7:0] expv = vc.wide ? vc.data : {1'b0, vc.data[6:0]};
      int bc = bit_clks(vc.div);
      wr_reg(4'd8, 16'h0000);
      wr_reg(4'd10, vc.div);
      wr_reg(4'd3, vc.wide ? 16'h0003 : 16'h0000);
      wr_reg(4'd8, 16'h0003);
      wr_reg(4'd0, {8'h00, vc.data});
      get_tx(bc, vc.wide, got, ok);
      check(vc.wide ? "R3 tx frame" : "R4 tx 7-bit frame", {7'd0, ok, got}, {8'h01, expv});
      repeat (bc) @(negedge clk);
      rd_check("R5 lstat has data", 4'd5, 16'h0061);
      rd_check(vc.wide ? "R5 rx data" : "R4 rx 7-bit data", 4'd0, {8'h00, expv});
    end
    loop_en = 1'b0;

    // R2 R10 R8 transmit queue depth, hold and flush
    wr_reg(4'd10, 16'd1);
    wr_reg(4'd3, 16'h0003);
    wr_reg(4'd8, 16'h0001);
    for (int i = 0; i < 9; i++) wr_reg(4'd0, 16'h0020 + 16'(i));
    rd_check("R2 tx level", 4'd9, 16'h0080);
    rd_check("R2 lstat full", 4'd5, 16'h0000);
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd_o !== 1'b1) lows++;
    end
    check("R10 tx held", 16'(lows), 16'd0);
    wr_reg(4'd2, 16'h0004);
    rd_check("R8 tx flush level", 4'd9, 16'h0000);
    rd_check("R8 tx flush lstat", 4'd5, 16'h0060);
    for (int i = 0; i < 9; i++) wr_reg(4'd0, 16'h0020 + 16'(i));
    wr_reg(4'd8, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      get_tx(16, 1'b1, got, ok);
      check("R2 tx order", {7'd0, ok, got}, {8'h01, 8'h20 + 8'(i)});
    end
    rd_check("R2 ninth dropped", 4'd9, 16'h0000);
    repeat (40) @(negedge clk);
    rd_check("R2 tx idle", 4'd5, 16'h0060);

    // R6 overrun
    for (int i = 0; i < 9; i++) send_rx(8'h30 + 8'(i), 1'b1, 16);
    rd_check("R6 rx level", 4'd9, 16'h0008);
    rd_check("R6 overrun set", 4'd5, 16'h0063);
    rd_check("R6 overrun cleared", 4'd5, 16'h0061);
    for (int i = 0; i < 8; i++) rd_check("R6 kept data", 4'd0, 16'h0030 + 16'(i));
    rd_check("R6 drained", 4'd5, 16'h0060);

    // R7 receive priority, then R8 receive flush
    wr_reg(4'd1, 16'h000F);
    send_rx(8'h5A, 1'b1, 16);
    rd_check("R7 rx priority iid", 4'd2, 16'h0004);
    check("R7 rx irq", {15'd0, irq_o}, 16'd1);
    wr_reg(4'd1, 16'h0000);
    wr_reg(4'd2, 16'h0002);
    rd_check("R8 rx flush", 4'd5, 16'h0060);

    // R10 receiver disabled
    wr_reg(4'd8, 16'h0002);
    send_rx(8'h77, 1'b1, 16);
    rd_check("R10 rx ignored", 4'd5, 16'h0060);
    wr_reg(4'd8, 16'h0003);

    // R13 short glitch rejected
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (3) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd_check("R13 glitch rejected", 4'd5, 16'h0060);

    // R9 break
    wr_reg(4'd3, 16'h0043);
    repeat (5) @(negedge clk);
    check("R9 break low", {15'd0, txd_o}, 16'd0);
    rd_check("R9 line readback", 4'd3, 16'h0043);
    wr_reg(4'd3, 16'h0003);
    check("R9 break released", {15'd0, txd_o}, 16'd1);

    finish_run();
  end

endmodule